// File: doc/BRIEF.md
# Sleep-State Supply Rail Sequencer

This block is the digital controller that decides, clock by clock, which of five supply rails may be switched on. It watches two active-low sleep requests, one for suspend and one for soft-off, along with a main-supply power-on flag, a per-rail in-regulation flag from the analog side and a one-cycle tick that marks the end of each soft-start period. It carries out a cold start, entry into suspend, resume from suspend, shutdown, and a latched shutdown when the fault block reports a fault. The ramps, comparators and regulation loops are outside the block and are seen only through these flags.

Rails come up in a fixed cascade, and each stage waits for the stage before it to report regulation. The memory-core rail stays on during suspend. Resume therefore repeats the cascade but leaves that rail as it was. The block also drives the control that shorts the memory termination reference to its output, so the termination rail floats while it is off. It drives an open-drain power-good pin as an output enable: the pin is pulled low until the cascade has settled and is released while the processor/graphics termination rail is in regulation.

Top module: `rail_sleep_seq`

## Requirements
- R1: While `rst_n` is low at a clock edge, the block takes its all-off state. In that state `rail_en` is 0, `term_ref_short` is 1 and `pg_pull_low` is 1.
- R2: With both requests high, the block first waits for `main_pg`. After `main_pg` is high it holds for exactly HOLD_TICKS (3) `ss_tick` pulses, and no new rail is enabled during the hold. Ticks that arrive before `main_pg` do not count.
- R3: After the hold, the first stage enables `rail_en[0]` (memory core) and `rail_en[1]` (upper graphics core). `rail_en[2]` (lower graphics core) follows one clock after rails 0 and 1 both report regulation.
- R4: `rail_en[3]` (processor/graphics termination) turns on one clock after rail 2 reports regulation.
- R5: `rail_en[4]` (memory termination) turns on one clock after rail 3 reports regulation.
- R6: A `rail_ok` bit counts only while the matching `rail_en` bit is 1. Set bits for disabled rails never advance the cascade.
- R7: `pg_pull_low` stays 1 until the first `ss_tick` after `rail_en[4]` went high. After that tick it is 0 exactly while `rail_ok[3]` is 1, and this follows `rail_ok[3]` in the same cycle.
- R8: `term_ref_short` is 1 whenever `rail_en[4]` is 0, and 0 whenever it is 1.
- R9: Suspend (`susp_req_n` low, `off_req_n` high) turns off rails 1 to 4 on the next edge, keeps `rail_en[0]` at its current value and pulls power-good low.
- R10: On resume (`susp_req_n` high again), `rail_en[0]` stays on. The POR wait and the 3-tick hold are repeated, and then the cascade restarts from the first stage.
- R11: Soft-off (`off_req_n` low) turns every enable off on the next edge and pulls power-good low. It takes priority over suspend.
- R12: `fault_kill` turns every enable off on the next edge. The block stays all-off after `fault_kill` falls, until `off_req_n` has been low for one edge with no fault present.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sequencer clock |
| rst_n | input | 1 | Synchronous active-low reset |
| susp_req_n | input | 1 | Suspend request, active low |
| off_req_n | input | 1 | Soft-off request, active low |
| main_pg | input | 1 | Main supply has passed its power-on threshold |
| ss_tick | input | 1 | One-cycle pulse at the end of each soft-start period |
| fault_kill | input | 1 | Global shutdown from the fault block |
| rail_ok | input | 5 | Per-rail in-regulation flags |
| rail_en | output | 5 | Per-rail enables (bit 0 core, 1 upper gfx, 2 lower gfx, 3 cpu/gfx term, 4 mem term) |
| term_ref_short | output | 1 | Shorts the memory termination reference to its output |
| pg_pull_low | output | 1 | Output enable of the open-drain power-good pin (1 = pull low) |

## Verification
On every cycle the assertions check the cascade ordering between enables, and that power-good is released only when the memory termination rail is on and rail 3 is in regulation. They also check that a fault, a soft-off request or a suspend request removes the required enables on the next edge, with the core rail held through suspend. Three behaviours can only be shown by the bench's scenarios: that the hold lasts exactly three ticks, that ticks before POR are ignored, and that sweeps over all `rail_ok` patterns never move a stage early. The same applies to recovery from a latched fault through soft-off.

// File: rtl/rail_seq_pkg.sv
// Package: shared state encoding and rail indices for the rail sequencer.
// Assumes the stage states are declared in cascade order, because the
// enable decoder compares state codes by magnitude.
package rail_seq_pkg;

    localparam int RAIL_CNT = 5;

    localparam int RAIL_CORE  = 0;
    localparam int RAIL_GFX_U = 1;
    localparam int RAIL_GFX_L = 2;
    localparam int RAIL_CTERM = 3;
    localparam int RAIL_MTERM = 4;

    typedef enum logic [3:0] {
        ST_OFF      = 4'd0,
        ST_WAIT_POR = 4'd1,
        ST_HOLD     = 4'd2,
        ST_STAGE1   = 4'd3,
        ST_STAGE2   = 4'd4,
        ST_STAGE3   = 4'd5,
        ST_STAGE4   = 4'd6,
        ST_RUN      = 4'd7,
        ST_SUSPEND  = 4'd8,
        ST_FAULT    = 4'd9
    } seq_state_e;

endpackage

// File: rtl/seq_fsm.sv
// Module: seq_fsm
// Main sequencing state machine. It steps through POR wait, the hold of
// HOLD_TICKS soft-start ticks and the cascade stages, and it also handles
// suspend, soft-off and latched fault. It remembers whether the core rail
// is on, so that rail survives suspend.
// Assumes ok_eff is already masked by the rail enables.
module seq_fsm
    import rail_seq_pkg::*;
#(
    parameter int HOLD_TICKS = 3
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                susp_req_n,
    input  logic                off_req_n,
    input  logic                main_pg,
    input  logic                ss_tick,
    input  logic                fault_kill,
    input  logic [RAIL_CNT-1:0] ok_eff,
    output seq_state_e          state,
    output logic                core_keep
);

    localparam int CNT_W = (HOLD_TICKS < 2) ? 1 : $clog2(HOLD_TICKS);
    localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(HOLD_TICKS - 1);

    seq_state_e       state_q, state_d;
    logic [CNT_W-1:0] cnt_q, cnt_d;
    logic             keep_q, keep_d;

    // Next-state selection. Priority is fault, then soft-off, then suspend,
    // then normal stepping.
    always_comb begin
        state_d = state_q;
        if (fault_kill) begin
            state_d = ST_FAULT;
        end else if (state_q == ST_FAULT) begin
            if (!off_req_n) state_d = ST_OFF;
        end else if (!off_req_n) begin
            state_d = ST_OFF;
        end else if (!susp_req_n) begin
            if (state_q != ST_OFF) state_d = ST_SUSPEND;
        end else begin
            unique case (state_q)
                ST_OFF, ST_SUSPEND: state_d = ST_WAIT_POR;
                ST_WAIT_POR: if (main_pg) state_d = ST_HOLD;
                ST_HOLD:     if (ss_tick && cnt_q == CNT_LAST) state_d = ST_STAGE1;
                ST_STAGE1:   if (ok_eff[RAIL_CORE] && ok_eff[RAIL_GFX_U]) state_d = ST_STAGE2;
                ST_STAGE2:   if (ok_eff[RAIL_GFX_L]) state_d = ST_STAGE3;
                ST_STAGE3:   if (ok_eff[RAIL_CTERM]) state_d = ST_STAGE4;
                ST_STAGE4:   if (ss_tick) state_d = ST_RUN;
                default:     state_d = state_q;
            endcase
        end
    end

    // Hold counter: counts ticks only while in the hold state.
    always_comb begin
        cnt_d = '0;
        if (state_q == ST_HOLD && state_d == ST_HOLD && ss_tick) cnt_d = cnt_q + 1'b1;
        else if (state_q == ST_HOLD && state_d == ST_HOLD)       cnt_d = cnt_q;
    end

    // Core-rail memory: set on entering stage 1, cleared on off or fault.
    always_comb begin
        keep_d = keep_q;
        if (state_d == ST_OFF || state_d == ST_FAULT) keep_d = 1'b0;
        else if (state_d == ST_STAGE1)                keep_d = 1'b1;
    end

    // State registers with synchronous active-low reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_OFF;
            cnt_q   <= '0;
            keep_q  <= 1'b0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
            keep_q  <= keep_d;
        end
    end

    assign state     = state_q;
    assign core_keep = keep_q;

endmodule

// File: rtl/rail_decode.sv
// Module: rail_decode
// Turns the sequencer state into rail enables, the termination reference
// short and the power-good arm flag. Assumes the stage states are numbered
// in cascade order, from ST_STAGE1 up to ST_RUN.
module rail_decode
    import rail_seq_pkg::*;
(
    input  seq_state_e          state,
    input  logic                core_keep,
    output logic [RAIL_CNT-1:0] rail_en,
    output logic                term_ref_short,
    output logic                pg_armed
);

    logic in_cascade;

    // Cascade window: any stage from stage 1 through run.
    always_comb in_cascade = (state >= ST_STAGE1) && (state <= ST_RUN);

    // Core rail: on through the cascade and wherever the memory keeps it.
    always_comb rail_en[RAIL_CORE] = in_cascade || core_keep;

    // Rails 1..4: rail i turns on from stage i until run.
    for (genvar gi = 1; gi < RAIL_CNT; gi++) begin : g_rail
        localparam logic [3:0] FIRST = 4'(ST_STAGE1) + 4'(gi - 1);
        always_comb rail_en[gi] = (4'(state) >= FIRST) && in_cascade;
    end

    // Reference short is held while the memory termination rail is off.
    always_comb term_ref_short = !rail_en[RAIL_MTERM];

    // Power-good comparison is enabled only in run.
    always_comb pg_armed = (state == ST_RUN);

endmodule

// File: rtl/pg_gate.sv
// Module: pg_gate
// Output enable for the open-drain power-good pin. The pin is pulled low
// unless the comparison is armed and the processor/graphics termination
// rail is both enabled and in regulation.
module pg_gate
    import rail_seq_pkg::*;
(
    input  logic                pg_armed,
    input  logic [RAIL_CNT-1:0] rail_en,
    input  logic [RAIL_CNT-1:0] rail_ok,
    output logic                pg_pull_low
);

    // Release the pin only when armed and the monitored rail is good.
    always_comb pg_pull_low = !(pg_armed && rail_en[RAIL_CTERM] && rail_ok[RAIL_CTERM]);

endmodule

// File: rtl/rail_sleep_seq.sv
// Module: rail_sleep_seq (top)
// Sleep-state power rail sequencer. It masks the regulation flags with the
// enables, runs the state machine and decodes the rail and pin outputs.
// Assumes ss_tick is a single-cycle pulse and all inputs are synchronous
// to clk.
module rail_sleep_seq
    import rail_seq_pkg::*;
#(
    parameter int HOLD_TICKS = 3
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                susp_req_n,
    input  logic                off_req_n,
    input  logic                main_pg,
    input  logic                ss_tick,
    input  logic                fault_kill,
    input  logic [RAIL_CNT-1:0] rail_ok,
    output logic [RAIL_CNT-1:0] rail_en,
    output logic                term_ref_short,
    output logic                pg_pull_low
);

    seq_state_e          state;
    logic                core_keep;
    logic                pg_armed;
    logic [RAIL_CNT-1:0] ok_eff;

    // A rail counts as regulated only while it is enabled.
    always_comb ok_eff = rail_ok & rail_en;

    seq_fsm #(.HOLD_TICKS(HOLD_TICKS)) u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .susp_req_n (susp_req_n),
        .off_req_n  (off_req_n),
        .main_pg    (main_pg),
        .ss_tick    (ss_tick),
        .fault_kill (fault_kill),
        .ok_eff     (ok_eff),
        .state      (state),
        .core_keep  (core_keep)
    );

    rail_decode u_dec (
        .state          (state),
        .core_keep      (core_keep),
        .rail_en        (rail_en),
        .term_ref_short (term_ref_short),
        .pg_armed       (pg_armed)
    );

    pg_gate u_pg (
        .pg_armed    (pg_armed),
        .rail_en     (rail_en),
        .rail_ok     (rail_ok),
        .pg_pull_low (pg_pull_low)
    );

endmodule

// File: rtl/rail_sleep_seq_chk.sv
// Module: rail_sleep_seq_chk
// Port-level checker for the sequencer. It is bound into every instance of
// the top module.
module rail_sleep_seq_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       susp_req_n,
    input logic       off_req_n,
    input logic       fault_kill,
    input logic [4:0] rail_ok,
    input logic [4:0] rail_en,
    input logic       term_ref_short,
    input logic       pg_pull_low
);

    // R3
    cascade_lower_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rail_en[2] |-> (rail_en[1] && rail_en[0]));

    // R4
    cascade_cterm_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rail_en[3] |-> rail_en[2]);

    // R5
    cascade_mterm_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rail_en[4] |-> rail_en[3]);

    // R7
    pg_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !pg_pull_low |-> (rail_en[4] && rail_ok[3]));

    // R8
    ref_short_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rail_en[4] |-> !term_ref_short);

    // R9
    suspend_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (off_req_n && !susp_req_n && !fault_kill) |=> (rail_en[4:1] == 4'b0 && pg_pull_low));

    // R9
    suspend_core_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (off_req_n && !susp_req_n && !fault_kill && rail_en[0]) |=> rail_en[0]);

    // R11
    softoff_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !off_req_n |=> (rail_en == 5'b0 && pg_pull_low));

    // R12
    fault_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fault_kill |=> (rail_en == 5'b0));

endmodule

bind rail_sleep_seq rail_sleep_seq_chk u_chk (
    .clk            (clk),
    .rst_n          (rst_n),
    .susp_req_n     (susp_req_n),
    .off_req_n      (off_req_n),
    .fault_kill     (fault_kill),
    .rail_ok        (rail_ok),
    .rail_en        (rail_en),
    .term_ref_short (term_ref_short),
    .pg_pull_low    (pg_pull_low)
);

// File: tb/rail_sleep_seq_tb.sv
// Bench for rail_sleep_seq. It runs directed sequences and sweeps the
// regulation-flag patterns inside each cascade stage.
module rail_sleep_seq_tb;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       susp_req_n = 1'b1;
    logic       off_req_n = 1'b1;
    logic       main_pg = 1'b0;
    logic       ss_tick = 1'b0;
    logic       fault_kill = 1'b0;
    logic [4:0] rail_ok = 5'b0;
    logic [4:0] rail_en;
    logic       term_ref_short;
    logic       pg_pull_low;

    int n_vec = 0;
    int n_bad = 0;

    always #5 clk = ~clk;

    rail_sleep_seq #(.HOLD_TICKS(3)) u_dut (
        .clk(clk), .rst_n(rst_n), .susp_req_n(susp_req_n), .off_req_n(off_req_n),
        .main_pg(main_pg), .ss_tick(ss_tick), .fault_kill(fault_kill),
        .rail_ok(rail_ok), .rail_en(rail_en), .term_ref_short(term_ref_short),
        .pg_pull_low(pg_pull_low)
    );

    task automatic cyc();
        @(posedge clk);
        #1;
    endtask

    task automatic tick();
        ss_tick = 1'b1;
        cyc();
        ss_tick = 1'b0;
    endtask

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_vec++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // Bring the block from off into run with all rails regulated.
    task automatic bring_up();
        off_req_n = 1'b1; susp_req_n = 1'b1; main_pg = 1'b1; rail_ok = 5'b0;
        cyc(); cyc();
        tick(); tick(); tick();
        rail_ok = 5'b11111;
        cyc(); cyc(); cyc();
        tick();
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog actual=running expected=finished");
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

    initial begin
        cyc(); cyc();
        // R1 reset state
        chk("R1 en", 32'(rail_en), 0);
        chk("R1 short", 32'(term_ref_short), 1);
        chk("R1 pg", 32'(pg_pull_low), 1);
        rst_n = 1'b1;

        // R2 cold start: POR wait, early tick ignored, 3-tick hold
        cyc();
        tick();
        cyc();
        chk("R2 pre-POR", 32'(rail_en), 0);
        main_pg = 1'b1;
        cyc();
        tick(); tick();
        chk("R2 hold after 2 ticks", 32'(rail_en), 0);
        tick();
        chk("R3 stage1", 32'(rail_en), 32'h03);

        // R6/R3 sweep: every flag pattern without both core and upper ok
        for (int p = 0; p < 32; p++) begin
            if ((p & 3) != 3) begin
                rail_ok = 5'(p);
                cyc();
                chk("R6 stage1 hold", 32'(rail_en), 32'h03);
            end
        end
        rail_ok = 5'b00011;
        cyc();
        chk("R3 stage2", 32'(rail_en), 32'h07);

        for (int p = 0; p < 32; p++) begin
            if ((p & 4) == 0) begin
                rail_ok = 5'(p);
                cyc();
                chk("R6 stage2 hold", 32'(rail_en), 32'h07);
            end
        end
        rail_ok = 5'b00111;
        cyc();
        chk("R4 stage3", 32'(rail_en), 32'h0F);
        chk("R8 short while mterm off", 32'(term_ref_short), 1);

        for (int p = 0; p < 32; p++) begin
            if ((p & 8) == 0) begin
                rail_ok = 5'(p);
                cyc();
                chk("R6 stage3 hold", 32'(rail_en), 32'h0F);
            end
        end
        rail_ok = 5'b01111;
        cyc();
        chk("R5 stage4", 32'(rail_en), 32'h1F);
        chk("R8 short released", 32'(term_ref_short), 0);
        chk("R7 pg before tick", 32'(pg_pull_low), 1);
        rail_ok = 5'b11111;
        cyc(); cyc();
        chk("R7 pg still low without tick", 32'(pg_pull_low), 1);
        tick();
        chk("R7 pg released", 32'(pg_pull_low), 0);
        rail_ok[3] = 1'b0;
        #1;
        chk("R7 pg follows rail 3 drop", 32'(pg_pull_low), 1);
        rail_ok[3] = 1'b1;
        #1;
        chk("R7 pg follows rail 3 return", 32'(pg_pull_low), 0);

        // R9 suspend
        susp_req_n = 1'b0;
        cyc();
        chk("R9 suspend en", 32'(rail_en), 32'h01);
        chk("R9 suspend pg", 32'(pg_pull_low), 1);
        chk("R8 suspend short", 32'(term_ref_short), 1);
        cyc(); cyc();
        chk("R9 suspend holds core", 32'(rail_en), 32'h01);

        // R10 resume
        susp_req_n = 1'b1; main_pg = 1'b0; rail_ok = 5'b00001;
        cyc();
        chk("R10 POR wait core on", 32'(rail_en), 32'h01);
        tick();
        main_pg = 1'b1;
        cyc();
        tick(); tick();
        chk("R10 hold core only", 32'(rail_en), 32'h01);
        tick();
        chk("R10 stage1", 32'(rail_en), 32'h03);
        rail_ok = 5'b11111;
        cyc(); cyc(); cyc();
        tick();
        chk("R10 resumed run en", 32'(rail_en), 32'h1F);
        chk("R10 resumed run pg", 32'(pg_pull_low), 0);

        // R11 soft-off beats suspend
        off_req_n = 1'b0; susp_req_n = 1'b0;
        cyc();
        chk("R11 off en", 32'(rail_en), 0);
        chk("R11 off pg", 32'(pg_pull_low), 1);
        susp_req_n = 1'b1;
        cyc(); cyc();
        chk("R11 stays off", 32'(rail_en), 0);

        // R12 fault latch and recovery through soft-off
        bring_up();
        chk("R12 run before fault", 32'(rail_en), 32'h1F);
        fault_kill = 1'b1;
        cyc();
        chk("R12 fault en", 32'(rail_en), 0);
        fault_kill = 1'b0;
        cyc(); cyc(); cyc();
        chk("R12 latched", 32'(rail_en), 0);
        chk("R12 latched pg", 32'(pg_pull_low), 1);
        off_req_n = 1'b0;
        cyc();
        off_req_n = 1'b1; rail_ok = 5'b0;
        cyc(); cyc();
        tick(); tick(); tick();
        chk("R12 recovered stage1", 32'(rail_en), 32'h03);

        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

endmodule